// File: doc/BRIEF.md
# Integration and Oversampling Sequencer

This block times an integrating converter front end from one system clock. A frame-start strobe, timed to the falling clock edge, opens an oversampling window of a fixed number of clock periods. When the window closes, the block pulses an internal reset that discharges the integrator and raises a data-valid flag. The flag stays up until the downstream reader acknowledges it. The integrator, the filter arithmetic and the serial readout sit outside the block.

Two reset modes exist. In continuous mode the reset lasts exactly one clock, and integration starts again at once. In non-continuous mode the reset holds until the frame strobe is released, so the host sets the dead time. The mode input is taken only while no frame is in progress.

Top module: `int_os_sequencer`

## Requirements
- R1: The frame strobe is captured on the falling clock edge. A strobe driven high between two rising edges makes `os_window` high from the rising edge after the next falling edge.
- R2: `os_window` stays high for exactly M clock cycles (parameter M, default 8), and `int_reset` goes high in the cycle right after the last window cycle.
- R3: With continuous mode latched (`cont_mode` = 1), `int_reset` is high for exactly one cycle, and `integrating` returns high in the next cycle.
- R4: With non-continuous mode latched (`cont_mode` = 0), `int_reset` stays high until the captured strobe is low. For a strobe held for H cycle slots, this gives a length of max(1, H − M) cycles.
- R5: `data_valid` goes high in the first reset cycle and stays high until `xmit_ack` is seen at a rising edge. It is low in the cycle after that.
- R6: `cont_mode` is sampled only while idle. Changing it during a window or a reset does not change that frame's reset length.
- R7: A new rising strobe edge during a window is ignored. A strobe still high when the block returns to idle does not start another window. Each frame gives exactly one window.
- R8: A synchronous active-high `rst` makes `os_window`, `int_reset` and `data_valid` low and `integrating` high in the next cycle, even in the middle of a frame.
- R9: `integrating` is low exactly in the cycles in which `int_reset` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame strobe, sampled on the falling clock edge |
| cont_mode | input | 1 | 1 = one-clock reset, 0 = reset held until the strobe is released |
| xmit_ack | input | 1 | Clears `data_valid` |
| os_window | output | 1 | Oversampling window in progress |
| integrating | output | 1 | Integrator is running |
| int_reset | output | 1 | Integrator reset pulse |
| data_valid | output | 1 | A completed frame awaits readout |

## Verification
The hardest case to reach is a mode change or a second strobe edge that lands in the middle of a running frame. The bench drives the strobe low and then high again partway through a window. In another frame it flips `cont_mode` after the window has opened. In both frames it measures the window and reset lengths over the whole frame. The non-continuous release point is swept across, below and at the window end, so that both branches of max(1, H − M) are reached.

// File: rtl/int_os_pkg.sv
package int_os_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_OSAMP, PH_RESET} phase_e;
endpackage

// File: rtl/iseq_strobe_capture.sv
module iseq_strobe_capture (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic strobe_s,
  output logic strobe_rise
);
  logic strobe_neg;
  logic strobe_prev;

  always_ff @(negedge clk) begin
    if (rst) strobe_neg <= 1'b0;
    else     strobe_neg <= strobe_in;
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_prev <= 1'b0;
    else     strobe_prev <= strobe_neg;
  end

  assign strobe_s    = strobe_neg;
  assign strobe_rise = strobe_neg & ~strobe_prev;
endmodule

// File: rtl/iseq_window_counter.sv
module iseq_window_counter #(
  parameter int M = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic last
);
  localparam int CW = (M > 1) ? $clog2(M) : 1;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= CW'(M - 1);
    else           cnt <= step_down(cnt);
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/int_os_sequencer.sv
module int_os_sequencer
  import int_os_pkg::*;
#(
  parameter int M = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic cont_mode,
  input  logic xmit_ack,
  output logic os_window,
  output logic integrating,
  output logic int_reset,
  output logic data_valid
);
  phase_e phase, phase_nx;
  logic   fs_s, fs_rise, cnt_last, mode_q;
  logic   start_evt, win_done, reset_exit;

  iseq_strobe_capture u_cap (
    .clk(clk), .rst(rst), .strobe_in(frame_start),
    .strobe_s(fs_s), .strobe_rise(fs_rise)
  );

  iseq_window_counter #(.M(M)) u_cnt (
    .clk(clk), .rst(rst), .load(start_evt), .last(cnt_last)
  );

  assign start_evt  = (phase == PH_IDLE) && fs_rise;
  assign win_done   = (phase == PH_OSAMP) && cnt_last;
  assign reset_exit = (phase == PH_RESET) && (mode_q || !fs_s);

  always_comb begin
    phase_nx = phase;
    if (start_evt)  phase_nx = PH_OSAMP;
    if (win_done)   phase_nx = PH_RESET;
    if (reset_exit) phase_nx = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      mode_q     <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (phase == PH_IDLE) mode_q <= cont_mode;
      if (win_done)         data_valid <= 1'b1;
      else if (xmit_ack)    data_valid <= 1'b0;
    end
  end

  assign os_window   = (phase == PH_OSAMP);
  assign int_reset   = (phase == PH_RESET);
  assign integrating = (phase != PH_RESET);

  AST_WIN_ENDS: assert property (@(posedge clk) disable iff (rst)
    win_done |=> (!os_window && int_reset));  // R2
  AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    win_done |=> data_valid);  // R5
  AST_CONT_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (int_reset && mode_q) |=> !int_reset);  // R3
  AST_NC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (int_reset && !mode_q && fs_s) |=> int_reset);  // R4
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (os_window || int_reset) |=> $stable(mode_q));  // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> (!os_window && !int_reset));  // R7
  AST_SYNC_RESET: assert property (@(posedge clk)
    rst |=> (!os_window && !int_reset && !data_valid));  // R8
endmodule

// File: tb/tb_int_os_sequencer.sv
module tb_int_os_sequencer;
  localparam int M = 8;

  logic clk = 1'b0;
  logic rst, frame_start, cont_mode, xmit_ack;
  logic os_window, integrating, int_reset, data_valid;
  int   n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  int_os_sequencer #(.M(M)) dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .cont_mode(cont_mode),
    .xmit_ack(xmit_ack), .os_window(os_window), .integrating(integrating),
    .int_reset(int_reset), .data_valid(data_valid)
  );

  // {mode, hold slots H}
  localparam logic [7:0] VEC [6] = '{
    {1'b1, 7'd1}, {1'b1, 7'd20}, {1'b0, 7'd2},
    {1'b0, 7'd8}, {1'b0, 7'd9},  {1'b0, 7'd14}
  };

  function automatic int exp_rst_len(input bit mode, input int h);
    if (mode) return 1;
    return (h - M > 1) ? h - M : 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_frame(input bit mode, input int h, input bit glitch, input bit flip,
                           output int os_first, output int os_len, output int rst_first,
                           output int rst_len, output int rises, output int integ_bad);
    bit last_os = 1'b0;
    os_first = -1; os_len = 0; rst_first = -1; rst_len = 0; rises = 0; integ_bad = 0;
    frame_start = 1'b1; cont_mode = mode;
    for (int c = 1; c <= 40; c++) begin
      tick();
      if (os_window) begin os_len++; if (os_first < 0) os_first = c; end
      if (int_reset) begin rst_len++; if (rst_first < 0) rst_first = c; end
      if (os_window && !last_os) rises++;
      last_os = os_window;
      if (integrating == int_reset) integ_bad++;
      if (c == h) frame_start = 1'b0;
      if (glitch && c == 3) frame_start = 1'b0;
      if (glitch && c == 4) frame_start = 1'b1;
      if (flip && c == 3) cont_mode = ~mode;
    end
    frame_start = 1'b0;
  endtask

  task automatic ack_and_check();
    xmit_ack = 1'b1; tick(); xmit_ack = 1'b0;
    check("R5 ack clears data_valid", data_valid, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int f, l, rf, rl, rs, ib;
    rst = 1'b1; frame_start = 1'b0; cont_mode = 1'b1; xmit_ack = 1'b0;
    tick(); tick(); rst = 1'b0; tick();
    check("R8 reset os_window", os_window, 0);
    check("R8 reset int_reset", int_reset, 0);
    check("R8 reset integrating", integrating, 1);
    check("R8 reset data_valid", data_valid, 0);

    foreach (VEC[i]) begin
      run_frame(VEC[i][7], int'(VEC[i][6:0]), 1'b0, 1'b0, f, l, rf, rl, rs, ib);
      check("R1 window start cycle", f, 1);
      check("R2 window length", l, M);
      check("R2 reset follows window", rf, M + 1);
      check(VEC[i][7] ? "R3 continuous reset length" : "R4 held reset length",
            rl, exp_rst_len(VEC[i][7], int'(VEC[i][6:0])));
      check("R7 single window per frame", rs, 1);
      check("R9 integrating vs int_reset", ib, 0);
      check("R5 data_valid held", data_valid, 1);
      ack_and_check();
    end

    // R7: strobe re-edge inside window
    run_frame(1'b1, M + 2, 1'b1, 1'b0, f, l, rf, rl, rs, ib);
    check("R7 glitch window length", l, M);
    check("R7 glitch single window", rs, 1);
    check("R7 glitch reset length", rl, 1);
    ack_and_check();

    // R6: mode flipped mid-frame, non-continuous kept
    run_frame(1'b0, M + 5, 1'b0, 1'b1, f, l, rf, rl, rs, ib);
    check("R6 mode frozen nc", rl, 5);
    ack_and_check();
    // R6: continuous kept despite flip
    run_frame(1'b1, M + 5, 1'b0, 1'b1, f, l, rf, rl, rs, ib);
    check("R6 mode frozen cont", rl, 1);
    ack_and_check();

    // R5: data_valid set without ack survives, ack with nothing pending stays low
    xmit_ack = 1'b1; tick(); xmit_ack = 1'b0;
    check("R5 idle ack keeps low", data_valid, 0);

    // R8: reset mid-window, and reset clears pending data_valid
    cont_mode = 1'b0; frame_start = 1'b1;
    tick(); tick(); tick();
    check("R8 window open before reset", os_window, 1);
    rst = 1'b1; tick(); rst = 1'b0; frame_start = 1'b0;
    check("R8 mid-window os_window", os_window, 0);
    check("R8 mid-window int_reset", int_reset, 0);
    check("R8 mid-window integrating", integrating, 1);
    run_frame(1'b1, 1, 1'b0, 1'b0, f, l, rf, rl, rs, ib);
    check("R5 valid before reset", data_valid, 1);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R8 reset clears data_valid", data_valid, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule